// File: doc/BRIEF.md
# Edge-Latched Status Register Bank

This block sits beside a framer's synchronization and alarm logic. It turns short or level-type status conditions into sticky bits that a host can pick up at its own pace. There are two groups of live status inputs. Seven belong to E1 frame/CRC-4 synchronization and five to T1 yellow alarms. Each input passes through a two-stage synchronizer. Its edges are then detected against a registered previous value. Whether a bit reacts to a rising edge, a falling edge or both is fixed per bit by parameter.

The host reaches the block over a small register bus with a read strobe, a write strobe, a 6-bit address and registered 16-bit read data. The bus exposes six registers:

- one latch register per group
- one interrupt-status register per group, which returns latched bits gated by the mask
- one mask register per group

Reading either the latch register or the interrupt-status register of a group clears that group's latched bits. Only the bits the read actually returned are cleared, so an event that arrives during the read is kept for the next one. The `irq` output is raised whenever any latched bit has its mask bit set.

Top module: `status_latch_bank`

## Requirements
- R1: E1 latch bits 0 to 3 (remote CRC-4/RAI timer A, timer B, consecutive frame-alignment errors, remote multiframe generator/detector failure) are set by a 0-to-1 transition of their live input only. A 1-to-0 transition leaves them unchanged.
- R2: E1 latch bits 4 to 6 (CRC-4 sync, multiframe alignment, basic frame alignment) are set by any transition of their live input.
- R3: T1 latch bits 0 to 3 (D4 yellow, D4 yellow 48 ms, secondary D4 yellow, ESF yellow) are set by a 0-to-1 transition only.
- R4: T1 latch bit 4 (T1DM yellow) is set by a 1-to-0 transition only.
- R5: A set latch bit stays set, whatever its live input does, until a clearing read of its group.
- R6: A read strobe at address 0x08 (E1 latch) or 0x09 (T1 latch) returns the latch register and clears the returned bits one clock after the strobe.
- R7: A read strobe at 0x0C (E1 interrupt status) or 0x0D (T1 interrupt status) returns latch AND mask for that group. It also clears that group's latch bits that were set at the read, one clock after the strobe.
- R8: After reset all latch, mask and read-data bits are 0. Read-data bits above the group width read as 0, and a read of any unmapped address returns 0.
- R9: A bit set in the same clock edge that samples a clearing read is not returned by that read and stays set afterwards.
- R10: A live input change applied before clock edge P0 sets its latch bit at edge P2. A read strobe sampled at P2 does not see it; one sampled at P3 does.
- R11: Writes to 0x10 (E1 mask) and 0x11 (T1 mask) store the mask, which reads back at the same address. `irq` is the OR over both groups of latch AND mask.
- R12: `rdData` changes only at the clock edge that samples a read strobe, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| e1Live | input | 7 | Live E1 synchronization status |
| t1Live | input | 5 | Live T1 alarm status |
| rdStb | input | 1 | Read strobe, one cycle per read |
| wrStb | input | 1 | Write strobe |
| addr | input | 6 | Register address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Registered read data |
| irq | output | 1 | Masked summary interrupt |

## Verification
Faults in the synchronizer or the previous-value stage show up as a latch bit that appears one edge early or late, or that appears on the wrong edge sense. The bench compares `rdData` and `irq` against its model on every clock, so such a fault is caught at the first read after the event, or at once through `irq` when the mask is set. A faulty clear path shows up differently. It either leaves a bit set on the next read, or drops an event that arrived during the read. The directed race case lines the set edge up exactly with the read sample to expose the second kind.

// File: rtl/status_latch_pkg.sv
package status_latch_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] ADDR_E1_LAT  = 6'h08;
  localparam logic [ADDR_W-1:0] ADDR_T1_LAT  = 6'h09;
  localparam logic [ADDR_W-1:0] ADDR_E1_INT  = 6'h0C;
  localparam logic [ADDR_W-1:0] ADDR_T1_INT  = 6'h0D;
  localparam logic [ADDR_W-1:0] ADDR_E1_MASK = 6'h10;
  localparam logic [ADDR_W-1:0] ADDR_T1_MASK = 6'h11;

  typedef struct packed {
    logic rdAny;
    logic rdE1Lat;
    logic rdT1Lat;
    logic rdE1Int;
    logic rdT1Int;
    logic rdE1Mask;
    logic rdT1Mask;
    logic wrE1Mask;
    logic wrT1Mask;
    logic clrE1;
    logic clrT1;
  } ctrlStb_t;
endpackage

// File: rtl/status_edge_bank.sv
module status_edge_bank #(
  parameter int          NUM  = 7,
  parameter logic [NUM-1:0] RISE = '1,
  parameter logic [NUM-1:0] FALL = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] live,
  output logic [NUM-1:0] setVec
);
  logic [NUM-1:0] meta;
  logic [NUM-1:0] syncd;
  logic [NUM-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta  <= '0;
      syncd <= '0;
      prev  <= '0;
    end else begin
      meta  <= live;
      syncd <= meta;
      prev  <= syncd;
    end
  end

  for (genvar b = 0; b < NUM; b++) begin : g_bit
    logic rose, fell;
    assign rose = syncd[b] & ~prev[b];
    assign fell = ~syncd[b] & prev[b];
    if (RISE[b] && FALL[b]) begin : g_both
      assign setVec[b] = rose | fell;
    end else if (RISE[b]) begin : g_rise
      assign setVec[b] = rose;
    end else if (FALL[b]) begin : g_fall
      assign setVec[b] = fell;
    end else begin : g_none
      assign setVec[b] = 1'b0;
    end
  end
endmodule

// File: rtl/status_latch_ctrl.sv
module status_latch_ctrl
  import status_latch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStb_t          stb
);
  logic clrE1Q, clrT1Q;

  always_comb begin
    stb          = '0;
    stb.rdAny    = rdStb;
    stb.rdE1Lat  = rdStb && (addr == ADDR_E1_LAT);
    stb.rdT1Lat  = rdStb && (addr == ADDR_T1_LAT);
    stb.rdE1Int  = rdStb && (addr == ADDR_E1_INT);
    stb.rdT1Int  = rdStb && (addr == ADDR_T1_INT);
    stb.rdE1Mask = rdStb && (addr == ADDR_E1_MASK);
    stb.rdT1Mask = rdStb && (addr == ADDR_T1_MASK);
    stb.wrE1Mask = wrStb && (addr == ADDR_E1_MASK);
    stb.wrT1Mask = wrStb && (addr == ADDR_T1_MASK);
    stb.clrE1    = clrE1Q;
    stb.clrT1    = clrT1Q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clrE1Q <= 1'b0;
      clrT1Q <= 1'b0;
    end else begin
      clrE1Q <= rdStb && (addr == ADDR_E1_LAT || addr == ADDR_E1_INT);
      clrT1Q <= rdStb && (addr == ADDR_T1_LAT || addr == ADDR_T1_INT);
    end
  end
endmodule

// File: rtl/status_latch_dp.sv
module status_latch_dp
  import status_latch_pkg::*;
#(
  parameter int NUM_E1 = 7,
  parameter int NUM_T1 = 5,
  parameter logic [NUM_E1-1:0] E1_RISE = 7'b1111111,
  parameter logic [NUM_E1-1:0] E1_FALL = 7'b1110000,
  parameter logic [NUM_T1-1:0] T1_RISE = 5'b01111,
  parameter logic [NUM_T1-1:0] T1_FALL = 5'b10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStb_t          stb,
  input  logic [NUM_E1-1:0] e1Live,
  input  logic [NUM_T1-1:0] t1Live,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic [NUM_E1-1:0] e1Lat,
  output logic [NUM_T1-1:0] t1Lat,
  output logic [NUM_E1-1:0] e1Set,
  output logic [NUM_T1-1:0] t1Set,
  output logic [NUM_E1-1:0] e1Mask,
  output logic [NUM_T1-1:0] t1Mask
);
  localparam int PAD_E1 = DATA_W - NUM_E1;
  localparam int PAD_T1 = DATA_W - NUM_T1;

  logic [NUM_E1-1:0] e1Snap;
  logic [NUM_T1-1:0] t1Snap;
  logic [DATA_W-1:0] rdNext;

  status_edge_bank #(.NUM(NUM_E1), .RISE(E1_RISE), .FALL(E1_FALL)) i_e1Edge (
    .clk(clk), .rst_n(rst_n), .live(e1Live), .setVec(e1Set));

  status_edge_bank #(.NUM(NUM_T1), .RISE(T1_RISE), .FALL(T1_FALL)) i_t1Edge (
    .clk(clk), .rst_n(rst_n), .live(t1Live), .setVec(t1Set));

  always_comb begin
    rdNext = '0;
    if (stb.rdE1Lat)  rdNext = {{PAD_E1{1'b0}}, e1Lat};
    if (stb.rdT1Lat)  rdNext = {{PAD_T1{1'b0}}, t1Lat};
    if (stb.rdE1Int)  rdNext = {{PAD_E1{1'b0}}, e1Lat & e1Mask};
    if (stb.rdT1Int)  rdNext = {{PAD_T1{1'b0}}, t1Lat & t1Mask};
    if (stb.rdE1Mask) rdNext = {{PAD_E1{1'b0}}, e1Mask};
    if (stb.rdT1Mask) rdNext = {{PAD_T1{1'b0}}, t1Mask};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e1Lat  <= '0;
      t1Lat  <= '0;
      e1Snap <= '0;
      t1Snap <= '0;
      e1Mask <= '0;
      t1Mask <= '0;
      rdData <= '0;
    end else begin
      e1Lat <= (stb.clrE1 ? (e1Lat & ~e1Snap) : e1Lat) | e1Set;
      t1Lat <= (stb.clrT1 ? (t1Lat & ~t1Snap) : t1Lat) | t1Set;
      if (stb.rdE1Lat || stb.rdE1Int) e1Snap <= e1Lat;
      if (stb.rdT1Lat || stb.rdT1Int) t1Snap <= t1Lat;
      if (stb.wrE1Mask) e1Mask <= wrData[NUM_E1-1:0];
      if (stb.wrT1Mask) t1Mask <= wrData[NUM_T1-1:0];
      if (stb.rdAny) rdData <= rdNext;
    end
  end

  assign irq = |(e1Lat & e1Mask) | |(t1Lat & t1Mask);
endmodule

// File: rtl/status_latch_bank.sv
module status_latch_bank
  import status_latch_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [6:0]  e1Live,
  input  logic [4:0]  t1Live,
  input  logic        rdStb,
  input  logic        wrStb,
  input  logic [5:0]  addr,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  output logic        irq
);
  ctrlStb_t   stb;
  logic [6:0] e1Lat, e1Set, e1Mask;
  logic [4:0] t1Lat, t1Set, t1Mask;

  status_latch_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .rdStb(rdStb), .wrStb(wrStb),
    .addr(addr), .stb(stb));

  status_latch_dp #(.NUM_E1(7), .NUM_T1(5)) i_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .e1Live(e1Live), .t1Live(t1Live), .wrData(wrData),
    .rdData(rdData), .irq(irq),
    .e1Lat(e1Lat), .t1Lat(t1Lat), .e1Set(e1Set), .t1Set(t1Set),
    .e1Mask(e1Mask), .t1Mask(t1Mask));
endmodule

// File: rtl/status_latch_chk.sv
module status_latch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rdStb,
  input logic [15:0] rdData,
  input logic        irq,
  input logic [6:0]  e1Lat,
  input logic [4:0]  t1Lat,
  input logic [6:0]  e1Set,
  input logic [4:0]  t1Set,
  input logic [6:0]  e1Mask,
  input logic [4:0]  t1Mask,
  input logic        clrE1,
  input logic        clrT1
);
  p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rdData[15:7] == 9'd0);

  p_sticky_e1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(e1Lat) & ~e1Lat) != 7'd0) |-> $past(clrE1));

  p_sticky_t1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(t1Lat) & ~t1Lat) != 5'd0) |-> $past(clrT1));

  p_set_needs_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((e1Lat & ~$past(e1Lat)) != 7'd0) |-> ($past(e1Set) != 7'd0));

  p_t1_set_needs_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((t1Lat & ~$past(t1Lat)) != 5'd0) |-> ($past(t1Set) != 5'd0));

  p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (e1Mask == 7'd0 && t1Mask == 5'd0) |-> !irq);

  p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rdStb) |-> $stable(rdData));
endmodule

bind status_latch_bank status_latch_chk i_chk (
  .clk(clk), .rst_n(rst_n), .rdStb(rdStb), .rdData(rdData), .irq(irq),
  .e1Lat(e1Lat), .t1Lat(t1Lat), .e1Set(e1Set), .t1Set(t1Set),
  .e1Mask(e1Mask), .t1Mask(t1Mask), .clrE1(stb.clrE1), .clrT1(stb.clrT1));

// File: tb/test_status_latch_bank.sv
`timescale 1ns/1ps
module test_status_latch_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  e1Live = '0;
  logic [4:0]  t1Live = '0;
  logic        rdStb = 1'b0;
  logic        wrStb = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  status_latch_bank i_status_latch_bank (
    .clk(clk), .rst_n(rst_n), .e1Live(e1Live), .t1Live(t1Live),
    .rdStb(rdStb), .wrStb(wrStb), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irq(irq));

  // Behavioural reference model
  bit [6:0]  e1Hist[$] = '{0, 0, 0};
  bit [4:0]  t1Hist[$] = '{0, 0, 0};
  bit [6:0]  mE1Lat, mE1Mask, mE1Snap;
  bit [4:0]  mT1Lat, mT1Mask, mT1Snap;
  bit        mPendE1, mPendT1;
  bit [15:0] mRd;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      mE1Lat = 0; mE1Mask = 0; mE1Snap = 0; mPendE1 = 0;
      mT1Lat = 0; mT1Mask = 0; mT1Snap = 0; mPendT1 = 0;
      mRd = 0;
      e1Hist = '{0, 0, 0};
      t1Hist = '{0, 0, 0};
    end else begin
      bit [6:0] oldE1, e1New, e1Old, setE1;
      bit [4:0] oldT1, t1New, t1Old, setT1;
      bit clrNextE1, clrNextT1;
      oldE1 = mE1Lat; oldT1 = mT1Lat;
      e1New = e1Hist[1]; e1Old = e1Hist[2];
      t1New = t1Hist[1]; t1Old = t1Hist[2];
      setE1 = ((e1New & ~e1Old) & 7'h7F) | ((~e1New & e1Old) & 7'h70);
      setT1 = ((t1New & ~t1Old) & 5'h0F) | ((~t1New & t1Old) & 5'h10);
      mE1Lat = (mPendE1 ? (oldE1 & ~mE1Snap) : oldE1) | setE1;
      mT1Lat = (mPendT1 ? (oldT1 & ~mT1Snap) : oldT1) | setT1;
      clrNextE1 = 0; clrNextT1 = 0;
      if (rdStb) begin
        case (addr)
          6'h08: begin mRd = {9'd0, oldE1}; clrNextE1 = 1; mE1Snap = oldE1; end
          6'h09: begin mRd = {11'd0, oldT1}; clrNextT1 = 1; mT1Snap = oldT1; end
          6'h0C: begin mRd = {9'd0, oldE1 & mE1Mask}; clrNextE1 = 1; mE1Snap = oldE1; end
          6'h0D: begin mRd = {11'd0, oldT1 & mT1Mask}; clrNextT1 = 1; mT1Snap = oldT1; end
          6'h10: mRd = {9'd0, mE1Mask};
          6'h11: mRd = {11'd0, mT1Mask};
          default: mRd = 0;
        endcase
      end
      mPendE1 = clrNextE1; mPendT1 = clrNextT1;
      if (wrStb && addr == 6'h10) mE1Mask = wrData[6:0];
      if (wrStb && addr == 6'h11) mT1Mask = wrData[4:0];
      e1Hist.push_front(e1Live); void'(e1Hist.pop_back());
      t1Hist.push_front(t1Live); void'(t1Hist.pop_back());
    end
  end

  // Every-cycle comparison against the model (R11 irq, R12 read data)
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (rdData !== mRd) begin
        errors++;
        $display("FAIL R12 model rdData actual=%h expected=%h", rdData, mRd);
      end
      checks++;
      if (irq !== (|(mE1Lat & mE1Mask) | |(mT1Lat & mT1Mask))) begin
        errors++;
        $display("FAIL R11 model irq actual=%b expected=%b", irq,
                 (|(mE1Lat & mE1Mask) | |(mT1Lat & mT1Mask)));
      end
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic readReg(input logic [5:0] a, output logic [15:0] v);
    addr = a; rdStb = 1'b1;
    @(negedge clk);
    rdStb = 1'b0;
    v = rdData;
    @(negedge clk);
  endtask

  task automatic writeReg(input logic [5:0] a, input logic [15:0] d);
    addr = a; wrData = d; wrStb = 1'b1;
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=<20000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R8 reset rdData", rdData, 16'h0000);
    check("R8 reset irq", {15'd0, irq}, 16'h0000);
    readReg(6'h08, v); check("R8 reset e1 latch", v, 16'h0000);

    // R1 rise on bit0, fall ignored
    e1Live = 7'h01; idle(4);
    readReg(6'h08, v); check("R1 rise sets bit0", v, 16'h0001);
    readReg(6'h08, v); check("R6 cleared after read", v, 16'h0000);
    e1Live = 7'h00; idle(4);
    readReg(6'h08, v); check("R1 fall ignored", v, 16'h0000);

    // R2 both edges on bit4
    e1Live = 7'h10; idle(4);
    readReg(6'h08, v); check("R2 rise bit4", v, 16'h0010);
    e1Live = 7'h00; idle(4);
    readReg(6'h08, v); check("R2 fall bit4", v, 16'h0010);

    // R3 / R4 T1 groups
    t1Live = 5'h0F; idle(4);
    readReg(6'h09, v); check("R3 rise bits0-3", v, 16'h000F);
    t1Live = 5'h1F; idle(4);
    readReg(6'h09, v); check("R4 rise bit4 ignored", v, 16'h0000);
    t1Live = 5'h00; idle(4);
    readReg(6'h09, v); check("R4 fall bit4 and R3 falls ignored", v, 16'h0010);

    // R5 sticky after live returns
    e1Live = 7'h02; idle(2); e1Live = 7'h00; idle(6);
    readReg(6'h08, v); check("R5 sticky bit1", v, 16'h0002);

    // R11 / R7 mask, irq and interrupt-status read
    writeReg(6'h10, 16'hFF02);
    readReg(6'h10, v); check("R11 mask readback", v, 16'h0002);
    e1Live = 7'h22; idle(4);
    check("R11 irq raised", {15'd0, irq}, 16'h0001);
    readReg(6'h0C, v); check("R7 int status masked", v, 16'h0002);
    readReg(6'h08, v); check("R7 int read cleared latch", v, 16'h0000);
    check("R11 irq low after clear", {15'd0, irq}, 16'h0000);
    e1Live = 7'h00; idle(4);
    readReg(6'h08, v); check("R2 fall bit5 only", v, 16'h0020);

    // R8 unmapped
    readReg(6'h3F, v); check("R8 unmapped reads zero", v, 16'h0000);

    // R9 / R10 race: change before P0, read sampled at P2 misses it
    e1Live = 7'h04; addr = 6'h08;
    @(negedge clk);          // P0 passed
    rdStb = 1'b1;            // wait: strobe sampled at P1 -> sees nothing
    @(negedge clk);
    check("R10 not visible at P1", rdData, 16'h0000);
    @(negedge clk);          // strobe sampled at P2, bit set at P2
    rdStb = 1'b0;
    check("R9 read at set edge misses bit", rdData, 16'h0000);
    idle(2);
    readReg(6'h08, v); check("R9 bit kept after racing read", v, 16'h0004);
    readReg(6'h08, v); check("R6 cleared after second read", v, 16'h0000);

    // R10 visibility at P3
    e1Live = 7'h0C; addr = 6'h08;
    idle(3);                 // P0, P1, P2 passed
    readReg(6'h08, v); check("R10 visible at P3", v, 16'h0008);
    idle(3);
    check("R12 rdData holds", rdData, 16'h0008);

    // T1 mask and irq
    writeReg(6'h11, 16'h0010);
    t1Live = 5'h10; idle(4); t1Live = 5'h00; idle(4);
    check("R11 T1 irq", {15'd0, irq}, 16'h0001);
    readReg(6'h0D, v); check("R7 T1 int status", v, 16'h0010);
    check("R7 T1 irq cleared", {15'd0, irq}, 16'h0000);

    idle(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule